// File: doc/BRIEF.md
# Serial Digital Potentiometer Command Decoder

This block is the command front end of a dual digital potentiometer. It sits on a four-wire serial bus as a slave in mode 0: data is taken on the rising edge of the serial clock, sent on the falling edge, and the most significant bit comes first. All bus inputs are oversampled by the local clock. Each transaction opens when chip select falls. The first byte names the device. The second byte carries an opcode, a register pointer and a potentiometer pointer. Some commands then take a third byte.

The decoder does not store any wiper positions or data registers. It reports each command as a one-cycle strobe with a command code, the selected potentiometer and register, and a six-bit payload. The storage and the write sequencer act on these strobes. For reads, the decoder publishes the selection, takes the matching six-bit value back on `rd_data`, and shifts it out on SO. An open-ended step mode turns every later rising clock edge into a one-step move of the wiper, upward or downward.

Top module: `spi_pot_cmd_decoder`

## Requirements
- R1: After reset, SO is high-impedance and `cmd_valid` and `step_valid` are low.
- R2: The first byte after chip select falls is accepted only when bits 7:4 equal 0101, bits 3:2 equal 00 and bits 1:0 equal `addr_pins`. Any other value makes the decoder ignore the rest of the transaction: no strobe, and SO stays released.
- R3: In the second byte, bits 7:4 are the opcode, bits 3:2 are the register select and bit 0 is the potentiometer select. These appear on `sel_reg` and `sel_pot` with every strobe. Bit 1 must be 0. The default opcodes are:
  - 0xD: data register to wiper
  - 0xE: wiper to data register
  - 0x1: global data register to wiper
  - 0x8: global wiper to data register
  - 0x9: read wiper
  - 0xA: write wiper
  - 0xB: read data register
  - 0xC: write data register
  - 0x5: read status
  - 0x2: step mode
- R4: The four transfer opcodes give exactly one `cmd_valid` pulse once the second byte completes. `cmd_op` is 0, 1, 2 and 3 in the order listed in R3. Any later bytes are ignored.
- R5: Write wiper and write data register give one `cmd_valid` pulse after the eighth bit of the third byte. `cmd_op` is 4 for a wiper write and 5 for a data register write. `cmd_data` carries bits 5:0 of that byte.
- R6: A wiper read or data register read sets `rd_wcr` (1 for the wiper, 0 for a data register). SO then shifts out 0, 0, then `rd_data` bits 5..0, MSB first. Each bit is valid at the matching rising clock edge of the third byte.
- R7: A status read shifts out seven zero bits followed by `wip` in bit 0.
- R8: SO is high-impedance except during the third byte of a read.
- R9: In step mode, every rising clock edge after the second byte gives one `step_valid` pulse. `step_up` equals SI at that edge. This continues until chip select rises.
- R10: A rising chip select abandons any partial byte or pending command without a strobe. Clock edges while chip select is high have no effect.
- R11: An opcode that is not listed in R3, or a second byte with bit 1 set, gives no strobe and no SO drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, tri-stated when idle |
| addr_pins | input | 2 | Strapped device address |
| wip | input | 1 | Write-in-progress flag from the sequencer |
| rd_data | input | 6 | Value of the selected register for reads |
| rd_wcr | output | 1 | Read source: 1 = wiper, 0 = data register |
| sel_pot | output | 1 | Selected potentiometer |
| sel_reg | output | 2 | Selected data register |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code (R4, R5) |
| cmd_data | output | 6 | Payload of a write command |
| step_valid | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 = up |

## Verification
The hardest situation to reach is the first bit of a read reply. SO must already hold the MSB when the first rising edge of the third byte arrives. The falling edge that follows the second byte must not shift the register early, and that edge comes only a few local clocks after the data is loaded. The bench sweeps all 16 opcodes across both potentiometers and all four registers, with `wip` tied to the potentiometer bit. It checks SO just before each rising edge, so a reply that is one bit off fails. A sweep of all 256 first-byte values, plus aborted and partial transactions, covers the ignore paths.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

   typedef enum logic [2:0] {
      ST_ID,
      ST_INSTR,
      ST_DATA,
      ST_STEP,
      ST_SKIP
   } dec_state_t;

   localparam logic [2:0] CMD_XFR_D2W  = 3'd0;
   localparam logic [2:0] CMD_XFR_W2D  = 3'd1;
   localparam logic [2:0] CMD_GXFR_D2W = 3'd2;
   localparam logic [2:0] CMD_GXFR_W2D = 3'd3;
   localparam logic [2:0] CMD_WR_WCR   = 3'd4;
   localparam logic [2:0] CMD_WR_DR    = 3'd5;

endpackage

// File: rtl/spi_pot_frontend.sv
module spi_pot_frontend #(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              cs_idle,
   output logic              sck_rise,
   output logic              sck_fall,
   output logic              si_bit,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CNT_W = $clog2(BYTE_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] cs_q, sck_q, si_q;
   logic                   sck_d;
   logic [CNT_W-1:0]       bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= '1;
         sck_q <= '0;
         si_q  <= '0;
         sck_d <= 1'b0;
      end else begin
         cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_n};
         sck_q <= {sck_q[SYNC_STAGES-2:0], sck};
         si_q  <= {si_q[SYNC_STAGES-2:0], si};
         sck_d <= sck_q[SYNC_STAGES-1];
      end
   end

   assign cs_idle  = cs_q[SYNC_STAGES-1];
   assign si_bit   = si_q[SYNC_STAGES-1];
   assign sck_rise = sck_q[SYNC_STAGES-1] & ~sck_d;
   assign sck_fall = ~sck_q[SYNC_STAGES-1] & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         byte_val  <= '0;
         byte_done <= 1'b0;
      end else if (cs_idle) begin
         bit_cnt   <= '0;
         byte_done <= 1'b0;
      end else if (sck_rise) begin
         byte_val  <= {byte_val[BYTE_W-2:0], si_bit};
         byte_done <= (bit_cnt == CNT_W'(BYTE_W-1));
         bit_cnt   <= (bit_cnt == CNT_W'(BYTE_W-1)) ? '0 : bit_cnt + 1'b1;
      end else begin
         byte_done <= 1'b0;
      end
   end

   // byte completion always follows a sampled rising edge
   p_byte_after_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(sck_rise));

endmodule

// File: rtl/spi_pot_readout.sv
module spi_pot_readout #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              sck_rise,
   input  logic              sck_fall,
   output logic              so_en,
   output logic              so_bit
);
   logic [BYTE_W-1:0] sh;
   logic              started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         so_en   <= 1'b0;
         started <= 1'b0;
      end else if (!active) begin
         so_en   <= 1'b0;
         started <= 1'b0;
      end else if (load) begin
         sh      <= load_val;
         so_en   <= 1'b1;
         started <= 1'b0;
      end else if (so_en) begin
         if (sck_rise) started <= 1'b1;
         if (sck_fall && started) sh <= {sh[BYTE_W-2:0], 1'b0};
      end
   end

   assign so_bit = sh[BYTE_W-1];

   p_so_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (so_en && $past(so_en) && !$past(sck_fall)) |-> $stable(so_bit));

   p_so_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !so_en);

endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
   import spi_pot_pkg::*;
#(
   parameter logic [3:0] ID_TYPE      = 4'b0101,
   parameter logic [3:0] OP_XFR_D2W   = 4'hD,
   parameter logic [3:0] OP_XFR_W2D   = 4'hE,
   parameter logic [3:0] OP_GXFR_D2W  = 4'h1,
   parameter logic [3:0] OP_GXFR_W2D  = 4'h8,
   parameter logic [3:0] OP_RD_WCR    = 4'h9,
   parameter logic [3:0] OP_WR_WCR    = 4'hA,
   parameter logic [3:0] OP_RD_DR     = 4'hB,
   parameter logic [3:0] OP_WR_DR     = 4'hC,
   parameter logic [3:0] OP_RD_STATUS = 4'h5,
   parameter logic [3:0] OP_STEP      = 4'h2,
   parameter int         DATA_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              sck_rise,
   input  logic              si_bit,
   input  logic              byte_done,
   input  logic [7:0]        byte_val,
   input  logic [1:0]        addr_pins,
   input  logic              wip,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [DATA_W-1:0] cmd_data,
   output logic              sel_pot,
   output logic [1:0]        sel_reg,
   output logic              rd_wcr,
   output logic              step_valid,
   output logic              step_up,
   output logic              rd_active,
   output logic              rd_load,
   output logic [7:0]        rd_val
);
   localparam int N_OPS = 10;
   localparam logic [3:0] OP_LIST [N_OPS] = '{OP_XFR_D2W, OP_XFR_W2D, OP_GXFR_D2W,
      OP_GXFR_W2D, OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR, OP_RD_STATUS, OP_STEP};

   function automatic int count_dups();
      int n = 0;
      for (int i = 0; i < N_OPS; i++)
         for (int j = i + 1; j < N_OPS; j++)
            if (OP_LIST[i] == OP_LIST[j]) n++;
      return n;
   endfunction

   generate
      if (count_dups() != 0) begin : g_dup_ops
         $error("opcode parameters must be distinct");
      end
      if (DATA_W != 6) begin : g_bad_width
         $error("payload layout fixes DATA_W at 6");
      end
   endgenerate

   dec_state_t  state;
   logic [2:0]  pend_op;
   logic        is_read, is_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_ID;
         cmd_valid  <= 1'b0;
         cmd_op     <= '0;
         cmd_data   <= '0;
         sel_pot    <= 1'b0;
         sel_reg    <= '0;
         rd_wcr     <= 1'b0;
         step_valid <= 1'b0;
         step_up    <= 1'b0;
         pend_op    <= '0;
         is_read    <= 1'b0;
         is_status  <= 1'b0;
         rd_load    <= 1'b0;
      end else begin
         cmd_valid  <= 1'b0;
         step_valid <= 1'b0;
         rd_load    <= 1'b0;
         if (cs_idle) begin
            state   <= ST_ID;
            is_read <= 1'b0;
         end else begin
            case (state)
               ST_ID: if (byte_done) begin
                  state <= (byte_val[7:4] == ID_TYPE && byte_val[3:2] == 2'b00 &&
                            byte_val[1:0] == addr_pins) ? ST_INSTR : ST_SKIP;
               end
               ST_INSTR: if (byte_done) begin
                  sel_pot <= byte_val[0];
                  sel_reg <= byte_val[3:2];
                  state   <= ST_SKIP;
                  if (!byte_val[1]) begin
                     case (byte_val[7:4])
                        OP_XFR_D2W:  begin cmd_valid <= 1'b1; cmd_op <= CMD_XFR_D2W;  end
                        OP_XFR_W2D:  begin cmd_valid <= 1'b1; cmd_op <= CMD_XFR_W2D;  end
                        OP_GXFR_D2W: begin cmd_valid <= 1'b1; cmd_op <= CMD_GXFR_D2W; end
                        OP_GXFR_W2D: begin cmd_valid <= 1'b1; cmd_op <= CMD_GXFR_W2D; end
                        OP_WR_WCR:   begin pend_op <= CMD_WR_WCR; state <= ST_DATA; end
                        OP_WR_DR:    begin pend_op <= CMD_WR_DR;  state <= ST_DATA; end
                        OP_RD_WCR: begin
                           is_read <= 1'b1; is_status <= 1'b0; rd_wcr <= 1'b1;
                           rd_load <= 1'b1; state <= ST_DATA;
                        end
                        OP_RD_DR: begin
                           is_read <= 1'b1; is_status <= 1'b0; rd_wcr <= 1'b0;
                           rd_load <= 1'b1; state <= ST_DATA;
                        end
                        OP_RD_STATUS: begin
                           is_read <= 1'b1; is_status <= 1'b1;
                           rd_load <= 1'b1; state <= ST_DATA;
                        end
                        OP_STEP: state <= ST_STEP;
                        default: state <= ST_SKIP;
                     endcase
                  end
               end
               ST_DATA: if (byte_done) begin
                  if (!is_read) begin
                     cmd_valid <= 1'b1;
                     cmd_op    <= pend_op;
                     cmd_data  <= byte_val[DATA_W-1:0];
                  end
                  is_read <= 1'b0;
                  state   <= ST_SKIP;
               end
               ST_STEP: if (sck_rise) begin
                  step_valid <= 1'b1;
                  step_up    <= si_bit;
               end
               default: ;
            endcase
         end
      end
   end

   // load one cycle after the selection registers settle
   assign rd_active = (state == ST_DATA) && is_read;
   assign rd_val    = is_status ? {7'b0, wip} : {2'b00, rd_data};

   p_cmd_on_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(byte_done));

   p_step_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |-> $past(sck_rise));

   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && step_valid));

   p_quiet_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> (!cmd_valid && !step_valid));

endmodule

// File: rtl/spi_pot_cmd_decoder.sv
module spi_pot_cmd_decoder #(
   parameter int         SYNC_STAGES  = 2,
   parameter logic [3:0] ID_TYPE      = 4'b0101,
   parameter logic [3:0] OP_XFR_D2W   = 4'hD,
   parameter logic [3:0] OP_XFR_W2D   = 4'hE,
   parameter logic [3:0] OP_GXFR_D2W  = 4'h1,
   parameter logic [3:0] OP_GXFR_W2D  = 4'h8,
   parameter logic [3:0] OP_RD_WCR    = 4'h9,
   parameter logic [3:0] OP_WR_WCR    = 4'hA,
   parameter logic [3:0] OP_RD_DR     = 4'hB,
   parameter logic [3:0] OP_WR_DR     = 4'hC,
   parameter logic [3:0] OP_RD_STATUS = 4'h5,
   parameter logic [3:0] OP_STEP      = 4'h2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   output logic       so,
   input  logic [1:0] addr_pins,
   input  logic       wip,
   input  logic [5:0] rd_data,
   output logic       rd_wcr,
   output logic       sel_pot,
   output logic [1:0] sel_reg,
   output logic       cmd_valid,
   output logic [2:0] cmd_op,
   output logic [5:0] cmd_data,
   output logic       step_valid,
   output logic       step_up
);
   localparam int BYTE_W = 8;
   localparam int DATA_W = 6;

   logic              cs_idle, sck_rise, sck_fall, si_bit, byte_done;
   logic [BYTE_W-1:0] byte_val, rd_val;
   logic              rd_active, rd_load, so_en, so_bit;

   spi_pot_frontend #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .cs_idle(cs_idle), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .si_bit(si_bit), .byte_done(byte_done), .byte_val(byte_val));

   spi_pot_decoder #(
      .ID_TYPE(ID_TYPE), .OP_XFR_D2W(OP_XFR_D2W), .OP_XFR_W2D(OP_XFR_W2D),
      .OP_GXFR_D2W(OP_GXFR_D2W), .OP_GXFR_W2D(OP_GXFR_W2D), .OP_RD_WCR(OP_RD_WCR),
      .OP_WR_WCR(OP_WR_WCR), .OP_RD_DR(OP_RD_DR), .OP_WR_DR(OP_WR_DR),
      .OP_RD_STATUS(OP_RD_STATUS), .OP_STEP(OP_STEP), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_rise(sck_rise),
      .si_bit(si_bit), .byte_done(byte_done), .byte_val(byte_val),
      .addr_pins(addr_pins), .wip(wip), .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .sel_pot(sel_pot), .sel_reg(sel_reg), .rd_wcr(rd_wcr),
      .step_valid(step_valid), .step_up(step_up),
      .rd_active(rd_active), .rd_load(rd_load), .rd_val(rd_val));

   spi_pot_readout #(.BYTE_W(BYTE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .active(rd_active), .load(rd_load),
      .load_val(rd_val), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .so_en(so_en), .so_bit(so_bit));

   assign so = so_en ? so_bit : 1'bz;

   p_so_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      so_en |-> !cs_idle || $past(!cs_idle));

endmodule

// File: tb/tb_spi_pot_cmd_decoder.sv
module tb_spi_pot_cmd_decoder;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wip = 1'b0;
   logic [1:0] addr_pins = 2'b10;
   wire  so;
   logic [5:0] rd_data;
   logic rd_wcr, sel_pot, cmd_valid, step_valid, step_up;
   logic [1:0] sel_reg;
   logic [2:0] cmd_op;
   logic [5:0] cmd_data;

   int n_checks = 0, n_err = 0;
   int n_cmd = 0, n_up = 0, n_dn = 0, n_drv = 0;
   logic [2:0] l_op;
   logic [5:0] l_data;
   logic       l_pot;
   logic [1:0] l_reg;

   always #5 clk = ~clk;

   spi_pot_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
      .addr_pins(addr_pins), .wip(wip), .rd_data(rd_data), .rd_wcr(rd_wcr),
      .sel_pot(sel_pot), .sel_reg(sel_reg), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .step_valid(step_valid),
      .step_up(step_up));

   // register bank model
   function automatic logic [5:0] wcr_m(input logic p);
      return p ? 6'h2A : 6'h15;
   endfunction
   function automatic logic [5:0] dr_m(input logic p, input logic [1:0] r);
      return 6'((({p, r}) * 7 + 3) & 63);
   endfunction
   assign rd_data = rd_wcr ? wcr_m(sel_pot) : dr_m(sel_pot, sel_reg);

   always @(negedge clk) begin
      if (cmd_valid) begin
         n_cmd++; l_op = cmd_op; l_data = cmd_data; l_pot = sel_pot; l_reg = sel_reg;
      end
      if (step_valid) begin
         if (step_up) n_up++; else n_dn++;
      end
      if (so !== 1'bz) n_drv++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr();
      n_cmd = 0; n_up = 0; n_dn = 0; n_drv = 0;
   endtask

   task automatic cs_on();
      cs_n = 1'b0; repeat (8) @(negedge clk);
   endtask
   task automatic cs_off();
      repeat (4) @(negedge clk); cs_n = 1'b1; repeat (8) @(negedge clk);
   endtask

   task automatic xbits(input logic [7:0] b, input int nbits, input bit rd,
                        input logic [7:0] exp, output int bad);
      bad = 0;
      for (int i = 7; i > 7 - nbits; i--) begin
         si = b[i];
         repeat (HALF) @(negedge clk);
         if (rd && so !== exp[i]) bad++;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      int bad;
      logic [7:0] instr, b3, exp_rd;
      int exp_cmd, exp_op, kind;
      repeat (3) @(negedge clk);
      chk("R1 so released", int'(so === 1'bz), 1);
      chk("R1 cmd_valid low", int'(cmd_valid), 0);
      chk("R1 step_valid low", int'(step_valid), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2: every first-byte value
      for (int id = 0; id < 256; id++) begin
         clr(); cs_on();
         xbits(8'(id), 8, 0, 8'h00, bad);
         xbits(8'hD5, 8, 0, 8'h00, bad);
         cs_off();
         chk($sformatf("R2 id=%02h strobes", id), n_cmd, (id == 8'h52) ? 1 : 0);
         chk("R2 R8 so idle", n_drv, 0);
      end
      // R2: each pin strap only answers its own address
      for (int pins = 0; pins < 4; pins++) begin
         addr_pins = 2'(pins);
         for (int a = 0; a < 4; a++) begin
            clr(); cs_on();
            xbits({6'b010100, 2'(a)}, 8, 0, 8'h00, bad);
            xbits(8'hE0, 8, 0, 8'h00, bad);
            cs_off();
            chk("R2 address pins", n_cmd, (a == pins) ? 1 : 0);
         end
      end
      addr_pins = 2'b10;

      // R3..R9, R11: opcode x pot x register sweep
      for (int op = 0; op < 16; op++)
         for (int p = 0; p < 2; p++)
            for (int r = 0; r < 4; r++) begin
               wip = p[0];
               instr = {4'(op), 2'(r), 1'b0, 1'(p)};
               b3 = {2'b11, 6'((op * 4 + r + p * 32) & 63)};
               exp_cmd = 0; exp_op = 0; kind = 0; exp_rd = 8'h00;
               case (op)
                  'hD: begin exp_cmd = 1; exp_op = 0; end
                  'hE: begin exp_cmd = 1; exp_op = 1; end
                  'h1: begin exp_cmd = 1; exp_op = 2; end
                  'h8: begin exp_cmd = 1; exp_op = 3; end
                  'hA: begin exp_cmd = 1; exp_op = 4; kind = 1; end
                  'hC: begin exp_cmd = 1; exp_op = 5; kind = 1; end
                  'h9: begin kind = 2; exp_rd = {2'b00, wcr_m(p[0])}; end
                  'hB: begin kind = 2; exp_rd = {2'b00, dr_m(p[0], 2'(r))}; end
                  'h5: begin kind = 2; exp_rd = {7'b0, p[0]}; end
                  'h2: kind = 3;
                  default: ;
               endcase
               clr(); cs_on();
               xbits(8'h52, 8, 0, 8'h00, bad);
               xbits(instr, 8, 0, 8'h00, bad);
               xbits(b3, 8, kind == 2, exp_rd, bad);
               cs_off();
               chk($sformatf("R4 R5 R11 op=%h strobe count", op), n_cmd, exp_cmd);
               if (exp_cmd == 1) begin
                  chk("R4 R5 cmd_op", int'(l_op), exp_op);
                  chk("R3 pot and register", int'({l_pot, l_reg}), p * 4 + r);
               end
               if (kind == 1) chk("R5 payload", int'(l_data), int'(b3[5:0]));
               if (kind == 2) begin
                  chk($sformatf("R6 R7 op=%h reply bit errors", op), bad, 0);
                  chk("R6 source select", int'(rd_wcr), (op == 'h9) ? 1 : 0);
               end
               chk("R8 so drive", int'(n_drv > 0), (kind == 2) ? 1 : 0);
               if (kind == 3) begin
                  chk("R9 up steps", n_up, $countones(b3));
                  chk("R9 down steps", n_dn, 8 - $countones(b3));
               end else begin
                  chk("R9 no steps", n_up + n_dn, 0);
               end
            end

      // R11: reserved bit set on a valid opcode
      clr(); cs_on();
      xbits(8'h52, 8, 0, 8'h00, bad);
      xbits(8'hD6, 8, 0, 8'h00, bad);
      cs_off();
      chk("R11 bit1 set ignored", n_cmd, 0);

      // R10: abort mid-instruction and mid-data, then a clean write
      clr(); cs_on();
      xbits(8'h52, 8, 0, 8'h00, bad);
      xbits(8'hC0, 4, 0, 8'h00, bad);
      cs_off();
      cs_on();
      xbits(8'h52, 8, 0, 8'h00, bad);
      xbits(8'hA1, 8, 0, 8'h00, bad);
      xbits(8'h3F, 7, 0, 8'h00, bad);
      cs_off();
      chk("R10 aborted writes", n_cmd, 0);
      cs_on();
      xbits(8'h52, 8, 0, 8'h00, bad);
      xbits(8'hA1, 8, 0, 8'h00, bad);
      xbits(8'h27, 8, 0, 8'h00, bad);
      cs_off();
      chk("R10 fresh transaction", n_cmd, 1);
      chk("R5 payload after abort", int'(l_data), 6'h27);

      // R9: long step run, then clocks with chip select high
      clr(); cs_on();
      xbits(8'h52, 8, 0, 8'h00, bad);
      xbits(8'h20, 8, 0, 8'h00, bad);
      xbits(8'hF0, 8, 0, 8'h00, bad);
      xbits(8'hFF, 8, 0, 8'h00, bad);
      xbits(8'h01, 8, 0, 8'h00, bad);
      cs_off();
      chk("R9 long run up", n_up, 13);
      chk("R9 long run down", n_dn, 11);
      clr();
      xbits(8'hAA, 8, 0, 8'h00, bad);
      chk("R10 clocks while deselected", n_cmd + n_up + n_dn + n_drv, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule